// File: doc/BRIEF.md
# Byte-Serial Curve Parameter Bank

This block holds the three wide constants that a binary-field point multiplier reads many times during one run: the affine x and y coordinates of the starting point and the curve coefficient b. Each value is 163 bits wide. Each is filled through one shared 8-bit byte port, one byte per clock, while an outside sequencer raises the write enable of the register it wants to fill. The least significant byte comes first. Twenty-one bytes complete a register, and only the low three bits of the last byte are kept.

After a register is full it ignores further bytes until its restart strobe clears it. The arithmetic unit can then read it any number of times through a 163-bit read port that a 2-bit select code steers. Each register reports its own full flag, and one combined flag shows that all three are ready. A register that is not full reads as zero, so a half-written operand never reaches the datapath.

Top module: `param_load_bank`

## Requirements
- R1: After reset every loaded flag and all_loaded are 0, and rd_data is 0 for every select code.
- R2: The k-th byte accepted by a register (k counted from 0, for k = 0..19) ends up in bits 8k to 8k+7 of that register's value.
- R3: The 21st accepted byte contributes only its bits 2:0, which become value bits 162:160. Its bits 7:3 are discarded.
- R4: A register's loaded flag goes high on the clock edge that accepts its 21st byte. Cycles in which its write enable is low do not advance the count.
- R5: While a register's loaded flag is high, bytes written to it are ignored and its value and flag stay unchanged.
- R6: A restart strobe for a register clears its value, byte count and loaded flag on the next edge. A byte offered to that register in the same cycle is discarded.
- R7: rd_sel code 0 reads the x register, 1 reads the y register, 2 reads the b register, and 3 reads all zeros.
- R8: rd_data is zero while the selected register's loaded flag is low.
- R9: all_loaded is high exactly when all three loaded flags are high.
- R10: Registers are independent. A write or restart on one leaves the others unchanged, and write enables raised together on several registers each take the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 3 | Per-register restart strobe (bit 0 x, bit 1 y, bit 2 b) |
| wr_en | input | 3 | Per-register byte write enable, same bit order |
| byte_in | input | 8 | Shared byte input |
| rd_sel | input | 2 | Read select: 0 x, 1 y, 2 b, 3 none |
| rd_data | output | 163 | Selected parameter, zero unless that register is loaded |
| loaded | output | 3 | Per-register full flag |
| all_loaded | output | 1 | All three registers full |

## Verification
The hardest cases to reach are the edges of a fill. One is the 21st byte with its upper five bits set, which must not leak past bit 162. Another is a restart that arrives in the same cycle as a write to the same register. The stimulus fills registers with gaps in the write enable and with bytes whose high bits are all ones. It keeps writing into a full register, and it fires a restart on the exact cycle a byte is offered. A behavioural model that places each byte by index is compared with the read port on every clock while the select code is moved around.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_PX   = 2'd0,
    SEL_PY   = 2'd1,
    SEL_B    = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  // Number of whole byte slots needed to cover a field of w bits.
  function automatic int unsigned bytes_for(input int unsigned w);
    return (w + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/plb_byte_shifter.sv
module plb_byte_shifter
  import plb_pkg::*;
#(
  parameter int unsigned FIELD_W = 163
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr,
  input  logic [BYTE_W-1:0]  din,
  output logic [FIELD_W-1:0] value,
  output logic               full,
  output logic               take
);
  localparam int unsigned NBYTES = bytes_for(FIELD_W);
  localparam int unsigned SR_W   = NBYTES * BYTE_W;
  localparam int unsigned CNT_W  = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES);

  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;

  // New byte enters at the top and everything moves down one slot; after
  // NBYTES pushes the first byte sits at bit 0 and the spare bits of the
  // final byte lie above FIELD_W, where they are dropped.
  function automatic logic [SR_W-1:0] push_byte(input logic [SR_W-1:0] cur,
                                                 input logic [BYTE_W-1:0] b);
    return {b, cur[SR_W-1:BYTE_W]};
  endfunction

  assign full  = (cnt == LAST);
  assign take  = wr & ~clr & ~full;
  assign value = sr[FIELD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clr) begin
      sr  <= '0;
      cnt <= '0;
    end else if (take) begin
      sr  <= push_byte(sr, din);
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/plb_out_sel.sv
module plb_out_sel #(
  parameter int unsigned FIELD_W = 163,
  parameter int unsigned NREG    = 3,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NREG*FIELD_W-1:0] bank,
  input  logic [NREG-1:0]         valid,
  input  logic [SEL_W-1:0]        sel,
  output logic [FIELD_W-1:0]      rd
);
  always_comb begin
    rd = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel == SEL_W'(i) && valid[i]) rd = bank[i*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/param_load_bank.sv
module param_load_bank
  import plb_pkg::*;
#(
  parameter int unsigned FIELD_W = 163,
  parameter int unsigned NREG    = 3,
  parameter int unsigned SEL_W   = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    ld_start,
  input  logic [NREG-1:0]    wr_en,
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [FIELD_W-1:0] rd_data,
  output logic [NREG-1:0]    loaded,
  output logic               all_loaded
);
  logic [NREG*FIELD_W-1:0] bank;
  logic [NREG-1:0]         byte_take;  // event: a byte entered register i

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    plb_byte_shifter #(.FIELD_W(FIELD_W)) u_shf (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ld_start[g]),
      .wr   (wr_en[g]),
      .din  (byte_in),
      .value(bank[g*FIELD_W +: FIELD_W]),
      .full (loaded[g]),
      .take (byte_take[g])
    );
  end

  plb_out_sel #(.FIELD_W(FIELD_W), .NREG(NREG), .SEL_W(SEL_W)) u_sel (
    .bank (bank),
    .valid(loaded),
    .sel  (rd_sel),
    .rd   (rd_data)
  );

  assign all_loaded = &loaded;
endmodule

// File: rtl/param_load_bank_chk.sv
module param_load_bank_chk #(
  parameter int unsigned FIELD_W = 163,
  parameter int unsigned NREG    = 3,
  parameter int unsigned SEL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREG-1:0]    ld_start,
  input logic [NREG-1:0]    loaded,
  input logic [NREG-1:0]    accept,
  input logic               all_loaded,
  input logic [SEL_W-1:0]   rd_sel,
  input logic [FIELD_W-1:0] rd_data
);
  localparam int unsigned PAD_W = 1 << SEL_W;
  logic [PAD_W-1:0] ld_pad;
  assign ld_pad = {{(PAD_W-NREG){1'b0}}, loaded};

  AST_FULL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept & loaded) == '0); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((loaded & $past(loaded & ~ld_start)) == $past(loaded & ~ld_start))); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_start != '0) |=> ((loaded & $past(ld_start)) == '0)); // R6

  AST_ALL_RISE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_loaded) |-> ($past(accept) != '0)); // R9

  AST_NONE_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_W'(NREG)) |-> (rd_data == '0)); // R7

  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_sel) && $past(ld_pad[rd_sel]) && $past(ld_start) == '0)
      |-> $stable(rd_data)); // R5
endmodule

bind param_load_bank param_load_bank_chk #(
  .FIELD_W(FIELD_W), .NREG(NREG), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_start  (ld_start),
  .loaded    (loaded),
  .accept    (byte_take),
  .all_loaded(all_loaded),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data)
);

// File: tb/param_load_bank_bench.sv
module param_load_bank_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   ld_start = '0;
  logic [2:0]   wr_en = '0;
  logic [7:0]   byte_in = '0;
  logic [1:0]   rd_sel = '0;
  logic [162:0] rd_data;
  logic [2:0]   loaded;
  logic         all_loaded;

  int n_tests = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  // Reference model: byte count and the value built by direct placement.
  int           m_cnt [3];
  logic [162:0] m_val [3];

  always #2 clk = ~clk;

  param_load_bank u_param_load_bank (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .wr_en(wr_en),
    .byte_in(byte_in), .rd_sel(rd_sel), .rd_data(rd_data),
    .loaded(loaded), .all_loaded(all_loaded)
  );

  task automatic check_outputs();
    logic [162:0] exp_rd;
    logic [2:0]   exp_ld;
    for (int i = 0; i < 3; i++) exp_ld[i] = (m_cnt[i] == 21);
    exp_rd = '0;
    if (rd_sel < 2'd3 && exp_ld[rd_sel]) exp_rd = m_val[rd_sel];
    n_tests++;
    if (rd_data !== exp_rd) begin
      n_fail++;
      $display("FAIL %s rd_data got %h exp %h", cur_tag, rd_data, exp_rd);
    end
    n_tests++;
    if (loaded !== exp_ld) begin
      n_fail++;
      $display("FAIL R4 loaded got %b exp %b", loaded, exp_ld);
    end
    n_tests++;
    if (all_loaded !== (&exp_ld)) begin
      n_fail++;
      $display("FAIL R9 all_loaded got %b exp %b", all_loaded, &exp_ld);
    end
  endtask

  // One clock: apply inputs, advance the model at the edge, compare at negedge.
  task automatic cyc(input logic [2:0] we, input logic [2:0] st,
                     input logic [7:0] d, input logic [1:0] sel);
    wr_en = we; ld_start = st; byte_in = d; rd_sel = sel;
    @(posedge clk);
    #0.5;
    for (int i = 0; i < 3; i++) begin
      if (st[i]) begin
        m_cnt[i] = 0;
        m_val[i] = '0;
      end else if (we[i] && m_cnt[i] < 21) begin
        if (m_cnt[i] < 20) m_val[i][8*m_cnt[i] +: 8] = d;
        else m_val[i][162:160] = d[2:0];
        m_cnt[i]++;
      end
    end
    @(negedge clk);
    check_outputs();
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 37 + seed * 101 + 5) ^ (k << 4));
  endfunction

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_val[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen on every select code
    cur_tag = "R1";
    for (int s = 0; s < 4; s++) cyc(3'b000, 3'b000, 8'hFF, 2'(s));

    // R2 / R3: fill x, last byte has its upper bits set; R8 zero until full
    cur_tag = "R8";
    for (int k = 0; k < 20; k++) cyc(3'b001, 3'b000, pat(k, 1), 2'd0);
    cur_tag = "R3";
    cyc(3'b001, 3'b000, 8'hFD, 2'd0);
    cur_tag = "R2";
    cyc(3'b000, 3'b000, 8'h00, 2'd0);

    // R5: further writes into a full register are ignored
    cur_tag = "R5";
    for (int k = 0; k < 5; k++) cyc(3'b001, 3'b000, 8'hA5, 2'd0);

    // R4: fill y with gaps in the write enable
    cur_tag = "R4";
    for (int k = 0; k < 42; k++)
      cyc((k % 2 == 0) ? 3'b010 : 3'b000, 3'b000, pat(k / 2, 2) | 8'h80, 2'd1);

    // R9: b nearly full keeps all_loaded low, then completes
    cur_tag = "R9";
    for (int k = 0; k < 20; k++) cyc(3'b100, 3'b000, pat(k, 3), 2'd2);
    cyc(3'b000, 3'b000, 8'h00, 2'd2);
    cyc(3'b100, 3'b000, 8'hFA, 2'd2);

    // R7: every select code
    cur_tag = "R7";
    for (int s = 0; s < 4; s++) cyc(3'b000, 3'b000, 8'h00, 2'(s));

    // R6: restart on y with a colliding write, then refill
    cur_tag = "R6";
    cyc(3'b010, 3'b010, 8'h3C, 2'd1);
    cyc(3'b000, 3'b000, 8'h00, 2'd1);
    for (int k = 0; k < 21; k++) cyc(3'b010, 3'b000, pat(k, 4), 2'd1);
    cyc(3'b000, 3'b000, 8'h00, 2'd1);

    // R10: restart x and b together, shared writes, y untouched
    cur_tag = "R10";
    cyc(3'b000, 3'b101, 8'h00, 2'd1);
    for (int k = 0; k < 21; k++) cyc(3'b101, 3'b000, pat(k, 5), 2'(k % 3));
    for (int s = 0; s < 4; s++) cyc(3'b000, 3'b000, 8'h00, 2'(s));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule